// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block decides which operating mode one digital PLL channel is in, and which frequency word drives that channel's oscillator. Its inputs are the reference-valid flag, the lock-detect flag, a software request for servo-driven operation, the word the closed loop currently produces, and a word written by an external timing servo. It keeps a smoothed record of the loop's word while the channel is locked. When the reference disappears it replays that record, so the output frequency stays where it was. The phase detector and the loop filter sit outside this block.

The channel has four modes. In free-run the oscillator gets no correction. In locked the loop word passes through and the loop is enabled. In holdover a frozen average of the past loop words is applied. In DCO the loop is opened and the servo word drives the oscillator.

The controller has four named transitions:
- acquire: free-run or holdover to locked.
- fallback: locked to holdover, or locked to free-run.
- servo entry: any mode to DCO.
- servo exit: DCO to free-run.

An update strobe marks each loop update period, and the average advances only on those strobes.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: After reset the mode output is free-run, the oscillator word is zero and loop enable is low. The mode code is 0 for free-run, 1 for locked, 2 for holdover and 3 for DCO.
- R2: In free-run the oscillator word is zero and loop enable is low. A valid reference without lock-detect keeps the channel in free-run.
- R3: Acquire: in free-run or holdover, with no DCO request, reference-valid and lock-detect both high at a clock edge select locked from that edge. While locked, the oscillator word equals the loop word input and loop enable is high.
- R4: The history advances only on an edge where the mode is locked, lock-detect is high and the update strobe is high. The history is a signed accumulator A holding the word scaled by 2^FRAC_W. When no update has been taken yet, the first update loads A = word·2^FRAC_W. Each later update computes A += (word·2^FRAC_W − A) >>> shift, with an arithmetic shift.
- R5: The history is valid once at least one update has been taken and the number of updates reaches the programmed minimum. The count saturates at its maximum.
- R6: Fallback: in locked, with no DCO request, a low reference-valid at an edge selects holdover if the history is valid, and free-run otherwise. A locked channel whose reference stays valid stays locked even if lock-detect drops.
- R7: In holdover the oscillator word is A >>> FRAC_W (floor), loop enable is low, and the word stays constant for as long as holdover lasts.
- R8: Servo entry: a DCO request at an edge selects DCO from any mode, ahead of every other transition. In DCO the oscillator word equals the servo word input and loop enable is low.
- R9: Servo exit: in DCO, a low DCO request at an edge selects free-run. Any stay in free-run discards the history, so a later fallback needs the minimum number of new updates before it can choose holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_ok | input | 1 | Selected reference is valid |
| lock_ok | input | 1 | Lock detector reports lock |
| dco_req | input | 1 | Software request for servo-driven (DCO) mode |
| upd_tick | input | 1 | Strobe marking one loop update period |
| hist_shift | input | SH_W | Averaging shift of the history filter |
| min_updates | input | CNT_W | Minimum number of updates before the history is valid |
| loop_word | input | FW | Signed frequency word from the loop filter |
| servo_word | input | FW | Signed frequency word written by the external servo |
| mode | output | 2 | Current mode code |
| loop_en | output | 1 | Loop enable |
| osc_word | output | FW | Signed frequency word applied to the oscillator |

## Verification
The assertions watch the mode transitions that do not depend on history on every cycle:
- servo entry and servo exit;
- acquire;
- that fallback lands in holdover or free-run;
- the zero word in free-run, the servo word passthrough in DCO, and the constant holdover word.

The numbers only the bench's scenarios can show are these:
- the averaged holdover value, which includes the seeding, fractional rounding and negative words;
- the exact update in which the history turns valid;
- the fact that lock-detect gaps add no update;
- the discarding of history after a trip through DCO and free-run.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_LOCK = 2'd1,
        MODE_HOLD = 2'd2,
        MODE_DCO  = 2'd3
    } mode_e;

endpackage

// File: rtl/dpll_hist_avg.sv
module dpll_hist_avg #(
    parameter int FW     = 24,
    parameter int FRAC_W = 8,
    parameter int SH_W   = 3,
    parameter int CNT_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 update,
    input  logic [FW-1:0]        word,
    input  logic [SH_W-1:0]      shift,
    input  logic [CNT_W-1:0]     min_cnt,
    output logic [FW-1:0]        hist_word,
    output logic                 valid
);
    localparam int AW = FW + FRAC_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] acc_n;
    logic signed [AW-1:0] target;
    logic signed [AW:0]   diff;
    logic signed [AW:0]   step;
    logic [CNT_W-1:0]     cnt_q;

    always_comb begin
        target = $signed({word, {FRAC_W{1'b0}}});
        diff   = $signed({target[AW-1], target}) - $signed({acc_q[AW-1], acc_q});
        step   = diff >>> shift;
        if (cnt_q == '0) begin
            acc_n = target;
        end else begin
            acc_n = acc_q + step[AW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (update) begin
            acc_q <= acc_n;
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign hist_word = acc_q[AW-1:FRAC_W];
    assign valid     = (cnt_q != '0) && (cnt_q >= min_cnt);

endmodule

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
    import dpll_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ref_ok,
    input  logic  lock_ok,
    input  logic  dco_req,
    input  logic  hist_valid,
    output mode_e mode
);
    mode_e state_q;
    mode_e state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_FREE;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        if (dco_req) begin
            state_n = MODE_DCO;                     // servo entry
        end else begin
            unique case (state_q)
                MODE_FREE: if (ref_ok && lock_ok) state_n = MODE_LOCK;   // acquire
                MODE_HOLD: if (ref_ok && lock_ok) state_n = MODE_LOCK;   // acquire
                MODE_LOCK: if (!ref_ok) state_n = hist_valid ? MODE_HOLD : MODE_FREE; // fallback
                MODE_DCO:  state_n = MODE_FREE;     // servo exit
                default:   state_n = MODE_FREE;
            endcase
        end
    end

    assign mode = state_q;

endmodule

// File: rtl/dpll_word_sel.sv
module dpll_word_sel
    import dpll_mode_pkg::*;
#(
    parameter int FW = 24
) (
    input  mode_e          mode,
    input  logic [FW-1:0]  loop_word,
    input  logic [FW-1:0]  servo_word,
    input  logic [FW-1:0]  hist_word,
    output logic [FW-1:0]  osc_word,
    output logic           loop_en
);
    always_comb begin
        osc_word = '0;
        loop_en  = 1'b0;
        unique case (mode)
            MODE_FREE: begin
                osc_word = '0;
                loop_en  = 1'b0;
            end
            MODE_LOCK: begin
                osc_word = loop_word;
                loop_en  = 1'b1;
            end
            MODE_HOLD: begin
                osc_word = hist_word;
                loop_en  = 1'b0;
            end
            MODE_DCO: begin
                osc_word = servo_word;
                loop_en  = 1'b0;
            end
            default: begin
                osc_word = '0;
                loop_en  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
    import dpll_mode_pkg::*;
#(
    parameter int FW     = 24,
    parameter int FRAC_W = 8,
    parameter int SH_W   = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_ok,
    input  logic              lock_ok,
    input  logic              dco_req,
    input  logic              upd_tick,
    input  logic [SH_W-1:0]   hist_shift,
    input  logic [CNT_W-1:0]  min_updates,
    input  logic [FW-1:0]     loop_word,
    input  logic [FW-1:0]     servo_word,
    output logic [1:0]        mode,
    output logic              loop_en,
    output logic [FW-1:0]     osc_word
);
    mode_e         cur_mode;
    logic          hist_valid;
    logic          hist_upd;
    logic          hist_clr;
    logic [FW-1:0] hist_word;

    assign hist_upd = upd_tick && lock_ok && (cur_mode == MODE_LOCK);
    assign hist_clr = (cur_mode == MODE_FREE);

    dpll_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_ok     (ref_ok),
        .lock_ok    (lock_ok),
        .dco_req    (dco_req),
        .hist_valid (hist_valid),
        .mode       (cur_mode)
    );

    dpll_hist_avg #(
        .FW     (FW),
        .FRAC_W (FRAC_W),
        .SH_W   (SH_W),
        .CNT_W  (CNT_W)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (hist_clr),
        .update    (hist_upd),
        .word      (loop_word),
        .shift     (hist_shift),
        .min_cnt   (min_updates),
        .hist_word (hist_word),
        .valid     (hist_valid)
    );

    dpll_word_sel #(
        .FW (FW)
    ) u_sel (
        .mode       (cur_mode),
        .loop_word  (loop_word),
        .servo_word (servo_word),
        .hist_word  (hist_word),
        .osc_word   (osc_word),
        .loop_en    (loop_en)
    );

    assign mode = cur_mode;

endmodule

// File: rtl/dpll_mode_ctrl_chk.sv
module dpll_mode_ctrl_chk #(
    parameter int FW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ref_ok,
    input logic          lock_ok,
    input logic          dco_req,
    input logic [FW-1:0] servo_word,
    input logic [1:0]    mode,
    input logic          loop_en,
    input logic [FW-1:0] osc_word
);
    AST_DCO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        dco_req |=> (mode == 2'd3)); // R8

    AST_DCO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> (osc_word == servo_word && !loop_en)); // R8

    AST_DCO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && !dco_req) |=> (mode == 2'd0)); // R9

    AST_FREE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> (osc_word == '0 && !loop_en)); // R2

    AST_ACQUIRE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd0 || mode == 2'd2) && ref_ok && lock_ok && !dco_req) |=> (mode == 2'd1)); // R3

    AST_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && !ref_ok && !dco_req) |=> (mode == 2'd2 || mode == 2'd0)); // R6

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |=> (mode != 2'd2 || $stable(osc_word))); // R7

endmodule

bind dpll_mode_ctrl dpll_mode_ctrl_chk #(.FW(FW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_ok     (ref_ok),
    .lock_ok    (lock_ok),
    .dco_req    (dco_req),
    .servo_word (servo_word),
    .mode       (mode),
    .loop_en    (loop_en),
    .osc_word   (osc_word)
);

// File: tb/dpll_mode_ctrl_test.sv
module dpll_mode_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int FW     = 24;
    localparam int FRAC_W = 8;
    localparam int SH_W   = 3;
    localparam int CNT_W  = 16;

    typedef struct {
        logic [1:0]    mode;
        logic [FW-1:0] word;
        logic          len;
        string         tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_ok = 1'b0;
    logic              lock_ok = 1'b0;
    logic              dco_req = 1'b0;
    logic              upd_tick = 1'b0;
    logic [SH_W-1:0]   hist_shift = 3'd1;
    logic [CNT_W-1:0]  min_updates = 16'd3;
    logic [FW-1:0]     loop_word = '0;
    logic [FW-1:0]     servo_word = '0;
    logic [1:0]        mode;
    logic              loop_en;
    logic [FW-1:0]     osc_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];

    int     m_mode = 0;
    longint m_acc  = 0;
    longint m_cnt  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpll_mode_ctrl #(
        .FW(FW), .FRAC_W(FRAC_W), .SH_W(SH_W), .CNT_W(CNT_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .lock_ok(lock_ok),
        .dco_req(dco_req), .upd_tick(upd_tick), .hist_shift(hist_shift),
        .min_updates(min_updates), .loop_word(loop_word), .servo_word(servo_word),
        .mode(mode), .loop_en(loop_en), .osc_word(osc_word)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (mode !== e.mode || osc_word !== e.word || loop_en !== e.len) begin
            errors++;
            $display("FAIL %s: mode=%0d word=%0d en=%0b expected mode=%0d word=%0d en=%0b",
                     e.tag, mode, $signed(osc_word), loop_en, e.mode, $signed(e.word), e.len);
        end
    endtask

    // Driver: applies inputs, advances the requirement model, queues the expectation.
    task automatic step(input bit r, input bit l, input bit d, input bit t,
                        input int lw, input int sw, input string tag);
        int nm;
        bit valid;
        longint lwl;
        longint word;
        exp_t e;
        @(negedge clk);
        ref_ok = r; lock_ok = l; dco_req = d; upd_tick = t;
        loop_word = lw[FW-1:0]; servo_word = sw[FW-1:0];
        lwl = longint'(lw);
        valid = (m_cnt != 0) && (m_cnt >= longint'(min_updates));
        if (d) nm = 3;
        else begin
            case (m_mode)
                0: nm = (r && l) ? 1 : 0;
                2: nm = (r && l) ? 1 : 2;
                1: nm = !r ? (valid ? 2 : 0) : 1;
                default: nm = 0;
            endcase
        end
        if (m_mode == 0) begin
            m_acc = 0; m_cnt = 0;
        end else if (m_mode == 1 && l && t) begin
            if (m_cnt == 0) m_acc = lwl <<< FRAC_W;
            else m_acc = m_acc + (((lwl <<< FRAC_W) - m_acc) >>> hist_shift);
            m_cnt++;
        end
        m_mode = nm;
        case (nm)
            0: word = 0;
            1: word = lwl;
            2: word = m_acc >>> FRAC_W;
            default: word = longint'(sw);
        endcase
        e.mode = nm[1:0];
        e.word = word[FW-1:0];
        e.len  = (nm == 1);
        e.tag  = tag;
        q.push_back(e);
    endtask

    // Monitor: samples a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t r0;
        repeat (3) @(negedge clk);
        r0.mode = 2'd0; r0.word = '0; r0.len = 1'b0; r0.tag = "R1 reset";
        compare(r0);
        rst_n = 1'b1;

        step(0, 0, 0, 0, 50, 0, "R2 idle");
        step(1, 0, 0, 0, 50, 0, "R2 ref without lock");
        step(1, 1, 0, 0, 1000, 0, "R3 acquire from free-run");
        step(1, 1, 0, 1, 1000, 0, "R4 seed update");
        step(1, 1, 0, 1, 2000, 0, "R4 second update");
        step(1, 0, 0, 1, 9000, 0, "R4 no update without lock");
        step(1, 1, 0, 1, -500, 0, "R5 third update makes history valid");
        step(0, 0, 0, 0, 7777, 0, "R6 fallback to holdover");
        step(0, 0, 0, 1, -3000, 0, "R7 holdover word frozen");
        step(0, 1, 0, 1, 12345, 0, "R7 holdover ignores loop word");
        step(1, 1, 0, 0, 400, 0, "R3 acquire from holdover");
        step(1, 1, 0, 1, 400, 0, "R4 update after reacquire");
        step(1, 1, 1, 1, 400, 5555, "R8 servo entry from locked");
        step(1, 1, 1, 1, 400, -77, "R8 servo word follows input");
        step(1, 1, 0, 0, 400, -77, "R9 servo exit to free-run");
        step(1, 1, 0, 0, 300, 0, "R3 acquire after servo exit");
        step(1, 1, 0, 1, 300, 0, "R4 fresh seed");
        step(0, 0, 0, 0, 300, 0, "R9 history discarded so fallback picks free-run");
        step(1, 1, 1, 0, 10, 42, "R8 servo request beats acquire");
        step(1, 1, 0, 0, 10, 42, "R9 exit again");
        hist_shift = 3'd0;
        min_updates = 16'd1;
        step(1, 1, 0, 0, -100, 0, "R3 acquire with shift zero");
        step(1, 1, 0, 1, -100, 0, "R4 seed negative");
        step(1, 1, 0, 1, -250, 0, "R4 shift zero tracks word");
        step(1, 0, 0, 0, 99, 0, "R6 stays locked while reference valid");
        step(0, 0, 0, 0, 99, 0, "R6 fallback to holdover with min of one");
        hist_shift = 3'd2;
        min_updates = 16'd2;
        step(1, 1, 0, 0, 0, 0, "R3 acquire before shift two");
        step(1, 1, 0, 1, 0, 0, "R4 update toward zero");
        step(0, 0, 0, 0, 0, 0, "R7 holdover of fractional average");
        step(0, 0, 1, 0, 0, 123, "R8 servo entry from holdover");
        step(0, 0, 0, 0, 0, 123, "R9 exit to free-run");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule